// File: doc/BRIEF.md
# I2C Bit-Level Line Controller

This block is the lowest layer of a single-master I2C engine. It owns the two open-drain bus wires and turns one command at a time into a timed waveform. The commands are start, repeated start, stop, write one bit and read one bit. A higher layer builds bytes, addresses and messages out of these commands. This block only knows about edges and phase lengths.

Each line is driven through an active-high pull-low enable. The observed line levels come back through a two-stage synchronizer. There are two timing values per speed, a low-phase length and a high-phase length, and every setup, hold and bus-free wait in the sequences uses one of them. Both are derived at elaboration time from the system clock frequency. Whenever the block lets SCL float high, it first waits until the wire really reads high, so that a target can stretch the clock. If the target holds SCL low for longer than a configurable limit, the block raises a sticky flag and carries on.

A start checks SDA before it does anything else. If a target is still holding SDA low from an interrupted transfer, the block gives one extra clock pulse to free the line, and then produces the start condition.

Top module: `i2c_line_ctrl`

## Requirements
- R1: After reset both pull-low enables are 0, `done`, `cmd_err` and `stretch_to` are 0, and `cmd_ready` is 1.
- R2: Phase length in cycles is CLK_HZ*ns/1e9 + 1, computed with integer division. With `speed_sel`=0 (standard) the low phase uses 4700 ns and the high phase 4000 ns. With `speed_sel`=1 (fast) they are 1300 ns and 600 ns. At 200 MHz this gives 941/801 cycles for standard and 261/121 cycles for fast.
- R3: A command with `speed_sel` of 2 or 3, or with a `cmd_op` code above 4, completes one cycle after acceptance. `done` and `cmd_err` are high together, and neither line enable changes. The op codes are 0 start, 1 repeated start, 2 stop, 3 write bit, 4 read bit.
- R4: Start with SDA reading high: SDA is pulled low while SCL is released. After one high phase SCL is pulled low. After one low phase `done` pulses.
- R5: Start with SDA reading low: SCL is pulled low for one low phase, then released, and after SCL reads high the block waits one more low phase. The normal start sequence of R4 follows.
- R6: Repeated start releases both lines, waits until SCL reads high, waits one high phase plus one low phase, and then runs the start of R4/R5.
- R7: Stop holds SDA low for one low phase, then releases SCL. After SCL reads high it waits two high phases, then releases SDA and waits one low phase before `done`.
- R8: Write bit sets the SDA enable to the inverse of `cmd_wbit` and releases SCL in the same cycle. It keeps SDA stable through the high phase and then pulls SCL low for one low phase.
- R9: Read bit releases SDA and SCL and samples SDA at the end of the high phase. It presents the sample on `rd_bit` together with `done`. `rd_bit` changes at no other time.
- R10: Every high phase is timed from the cycle in which the synchronized SCL first reads high. A target holding SCL low delays the end of the phase.
- R11: If SCL stays low for STRETCH_TO cycles after release, `stretch_to` is set. The high phase is then timed anyway and the command completes. `stretch_to` stays set until reset.
- R12: `cmd_ready` is high only while idle. A `cmd_valid` raised while busy has no effect on the lines or on `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_op | input | 3 | Command code (see R3) |
| cmd_wbit | input | 1 | Data bit for a write-bit command |
| speed_sel | input | 2 | Speed select: 0 standard, 1 fast, others invalid |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | Bit sampled by the last read-bit command |
| cmd_err | output | 1 | Pulses with `done` for a rejected command |
| stretch_to | output | 1 | Sticky clock-stretch timeout flag |
| scl_in | input | 1 | Observed SCL level |
| sda_in | input | 1 | Observed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest situations to reach are those where the bus wires disagree with what the block drives. These are a target that keeps SDA low when a start is requested, and a target that holds SCL low after release, both shortly and past the timeout. The bench models the open-drain wires as the AND of the block's enables with target pull-down flags that the tests control. One test releases the stuck SDA only when it sees the recovery clock pulse. Another drops its SCL hold a fixed number of cycles after release, so the measured high phase shows it was timed from the observed edge.

// File: rtl/i2c_line_pkg.sv
package i2c_line_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4
  } op_e;

  localparam logic [1:0] SPD_STD  = 2'd0;
  localparam logic [1:0] SPD_FAST = 2'd1;

  localparam longint unsigned NS_STD_LO  = 64'd4700;
  localparam longint unsigned NS_STD_HI  = 64'd4000;
  localparam longint unsigned NS_FAST_LO = 64'd1300;
  localparam longint unsigned NS_FAST_HI = 64'd600;

  typedef enum logic [3:0] {
    S_IDLE, S_RS_REL, S_CHK, S_REC_LO, S_REC_HI, S_ST_SDA, S_ST_SCL,
    S_SP_SDA, S_SP_SCL, S_SP_REL, S_BIT_HI, S_BIT_LO
  } seq_e;

  function automatic longint unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
    return (hz * ns) / 64'd1_000_000_000 + 64'd1;
  endfunction

endpackage

// File: rtl/i2c_sync2.sv
module i2c_sync2 #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  // Idle bus lines read high, so the flops reset to 1.
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/i2c_phase_sel.sv
module i2c_phase_sel
  import i2c_line_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd200_000_000,
  parameter int              TW     = 12
) (
  input  logic [1:0]    speed,
  output logic [TW-1:0] t_low,
  output logic [TW-1:0] t_high,
  output logic          ok
);
  localparam logic [TW-1:0] STD_LO  = TW'(ns_to_cyc(CLK_HZ, NS_STD_LO));
  localparam logic [TW-1:0] STD_HI  = TW'(ns_to_cyc(CLK_HZ, NS_STD_HI));
  localparam logic [TW-1:0] FAST_LO = TW'(ns_to_cyc(CLK_HZ, NS_FAST_LO));
  localparam logic [TW-1:0] FAST_HI = TW'(ns_to_cyc(CLK_HZ, NS_FAST_HI));

  always_comb begin
    t_low  = STD_LO;
    t_high = STD_HI;
    ok     = 1'b1;
    case (speed)
      SPD_STD:  ;
      SPD_FAST: begin
        t_low  = FAST_LO;
        t_high = FAST_HI;
      end
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int TW         = 12,
  parameter int STRETCH_TO = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_len,
  input  logic          gate,
  input  logic          scl_hi,
  output logic          expired,
  output logic          tmo
);
  localparam int SW = $clog2(STRETCH_TO + 1);
  localparam logic [SW-1:0] TO_LAST = SW'(STRETCH_TO - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sc_q, sc_d;
  logic          hold_q, hold_d;
  logic          en;

  assign en      = load | hold_q | (cnt_q != '0);
  assign tmo     = hold_q & ~scl_hi & (sc_q == TO_LAST);
  assign expired = ~hold_q & (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    sc_d   = sc_q;
    hold_d = hold_q;
    if (load) begin
      cnt_d  = load_len - TW'(1);
      hold_d = gate;
      sc_d   = '0;
    end else if (hold_q) begin
      if (scl_hi || sc_q == TO_LAST) hold_d = 1'b0;
      else                           sc_d   = sc_q + SW'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sc_q   <= '0;
      hold_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      sc_q   <= sc_d;
      hold_q <= hold_d;
    end
  end

  // R10
  stretch_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> ($past(scl_hi) || $past(sc_q) == TO_LAST));
endmodule

// File: rtl/i2c_line_ctrl.sv
module i2c_line_ctrl
  import i2c_line_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 64'd200_000_000,
  parameter int              STRETCH_TO = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic       cmd_wbit,
  input  logic [1:0] speed_sel,
  output logic       done,
  output logic       rd_bit,
  output logic       cmd_err,
  output logic       stretch_to,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam longint unsigned MAX_LO = ns_to_cyc(CLK_HZ, NS_STD_LO);
  localparam longint unsigned MAX_HI = ns_to_cyc(CLK_HZ, NS_STD_HI);
  localparam int TW = $clog2(MAX_LO + 2 * MAX_HI + 1);

  seq_e          state_q, state_d;
  logic          scl_q, scl_d, sda_q, sda_d;
  logic          done_q, done_d, err_q, err_d;
  logic          rd_q, rd_d, cap_q, cap_d, isrd_q, isrd_d;
  logic [1:0]    spd_q, spd_d, spd_mux;
  logic          to_q;
  logic          ld, ld_gate, tdone, tmo, bad;
  logic [TW-1:0] ld_len, t_lo, t_hi;
  logic          spd_ok, scl_s, sda_s;

  i2c_sync2 #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  assign spd_mux = (state_q == S_IDLE) ? speed_sel : spd_q;

  i2c_phase_sel #(.CLK_HZ(CLK_HZ), .TW(TW)) u_sel (
    .speed(spd_mux), .t_low(t_lo), .t_high(t_hi), .ok(spd_ok)
  );

  i2c_phase_timer #(.TW(TW), .STRETCH_TO(STRETCH_TO)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_len(ld_len), .gate(ld_gate),
    .scl_hi(scl_s), .expired(tdone), .tmo(tmo)
  );

  assign bad       = !spd_ok || (cmd_op > 3'd4);
  assign cmd_ready = (state_q == S_IDLE);

  always_comb begin
    state_d = state_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    rd_d    = rd_q;
    cap_d   = cap_q;
    isrd_d  = isrd_q;
    spd_d   = spd_q;
    ld      = 1'b0;
    ld_len  = t_lo;
    ld_gate = 1'b0;
    case (state_q)
      S_IDLE: if (cmd_valid) begin
        spd_d  = speed_sel;
        isrd_d = 1'b0;
        if (bad) begin
          done_d = 1'b1;
          err_d  = 1'b1;
        end else begin
          case (cmd_op)
            OP_START:  state_d = S_CHK;
            OP_RSTART: begin
              state_d = S_RS_REL; sda_d = 1'b0; scl_d = 1'b0;
              ld = 1'b1; ld_len = t_hi + t_lo; ld_gate = 1'b1;
            end
            OP_STOP: begin
              state_d = S_SP_SDA; sda_d = 1'b1; ld = 1'b1; ld_len = t_lo;
            end
            default: begin
              state_d = S_BIT_HI; scl_d = 1'b0;
              sda_d   = (cmd_op == OP_WRITE) ? ~cmd_wbit : 1'b0;
              isrd_d  = (cmd_op == OP_READ);
              ld = 1'b1; ld_len = t_hi; ld_gate = 1'b1;
            end
          endcase
        end
      end
      S_RS_REL: if (tdone) state_d = S_CHK;
      S_CHK: begin
        ld = 1'b1;
        if (!sda_s) begin
          state_d = S_REC_LO; scl_d = 1'b1; ld_len = t_lo;
        end else begin
          state_d = S_ST_SDA; sda_d = 1'b1; ld_len = t_hi;
        end
      end
      S_REC_LO: if (tdone) begin
        state_d = S_REC_HI; scl_d = 1'b0; ld = 1'b1; ld_len = t_lo; ld_gate = 1'b1;
      end
      S_REC_HI: if (tdone) begin
        state_d = S_ST_SDA; sda_d = 1'b1; ld = 1'b1; ld_len = t_hi;
      end
      S_ST_SDA: if (tdone) begin
        state_d = S_ST_SCL; scl_d = 1'b1; ld = 1'b1; ld_len = t_lo;
      end
      S_SP_SDA: if (tdone) begin
        state_d = S_SP_SCL; scl_d = 1'b0; ld = 1'b1; ld_len = t_hi << 1; ld_gate = 1'b1;
      end
      S_SP_SCL: if (tdone) begin
        state_d = S_SP_REL; sda_d = 1'b0; ld = 1'b1; ld_len = t_lo;
      end
      S_BIT_HI: if (tdone) begin
        state_d = S_BIT_LO; scl_d = 1'b1; ld = 1'b1; ld_len = t_lo;
        if (isrd_q) cap_d = sda_s;
      end
      S_BIT_LO: if (tdone) begin
        state_d = S_IDLE; done_d = 1'b1;
        if (isrd_q) rd_d = cap_q;
      end
      S_ST_SCL, S_SP_REL: if (tdone) begin
        state_d = S_IDLE; done_d = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= 1'b0;
      cap_q   <= 1'b0;
      isrd_q  <= 1'b0;
      spd_q   <= SPD_STD;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
      err_q   <= err_d;
      rd_q    <= rd_d;
      cap_q   <= cap_d;
      isrd_q  <= isrd_d;
      spd_q   <= spd_d;
      if (tmo) to_q <= 1'b1;
    end
  end

  assign scl_oe     = scl_q;
  assign sda_oe     = sda_q;
  assign done       = done_q;
  assign cmd_err    = err_q;
  assign rd_bit     = rd_q;
  assign stretch_to = to_q;

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !bad) |=> !cmd_ready);
  // R11
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_to |=> stretch_to);
  // R9
  rdbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rd_bit));
  // R3
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> done);
  // R8
  wr_sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BIT_HI && $past(state_q) == S_BIT_HI) |-> $stable(sda_oe));
  // R4
  start_scl_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ST_SDA) |-> !scl_oe);
endmodule

// File: tb/sim_i2c_line_ctrl.sv
module sim_i2c_line_ctrl;
  localparam int TO = 1000;
  localparam int SL = 941, SH = 801, FL = 261, FH = 121;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_wbit = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] speed_sel = 2'd1;
  logic cmd_ready, done, rd_bit, cmd_err, stretch_to, scl_oe, sda_oe;
  logic tgt_scl_hold = 1'b0, tgt_sda_low = 1'b0;
  logic scl_in, sda_in;

  assign scl_in = !scl_oe && !tgt_scl_hold;
  assign sda_in = !sda_oe && !tgt_sda_low;

  always #2.5 clk = ~clk;

  i2c_line_ctrl #(.STRETCH_TO(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wbit(cmd_wbit), .speed_sel(speed_sel), .done(done),
    .rd_bit(rd_bit), .cmd_err(cmd_err), .stretch_to(stretch_to),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_sp, n_sr, n_dp, n_dr, n_done, t_acc, t_done, t_dp, t_dr;
  int t_sp[4], t_sr[4];
  logic p_scl = 1'b0, p_sda = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (scl_oe && !p_scl) begin if (n_sp < 4) t_sp[n_sp] = cyc; n_sp++; end
    if (!scl_oe && p_scl) begin if (n_sr < 4) t_sr[n_sr] = cyc; n_sr++; end
    if (sda_oe && !p_sda) begin t_dp = cyc; n_dp++; end
    if (!sda_oe && p_sda) begin t_dr = cyc; n_dr++; end
    if (done) n_done++;
    p_scl = scl_oe;
    p_sda = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    chk(act >= lo && act <= hi, req, act, lo);
  endtask

  task automatic issue(input logic [2:0] op, input logic wb, input logic [1:0] spd);
    @(negedge clk);
    n_sp = 0; n_sr = 0; n_dp = 0; n_dr = 0; n_done = 0;
    cmd_op = op; cmd_wbit = wb; speed_sel = spd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    t_acc = cyc;
  endtask

  task automatic wait_done(input string req);
    int g = 0;
    while (!done && g < 20000) begin @(negedge clk); g++; end
    chk(done, req, 0, 1);
    t_done = cyc;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_eq("R1 scl_oe", scl_oe, 0);
    chk_eq("R1 sda_oe", sda_oe, 0);
    chk_eq("R1 done", done, 0);
    chk_eq("R1 cmd_err", cmd_err, 0);
    chk_eq("R1 stretch_to", stretch_to, 0);
    chk_eq("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_reject;
    issue(3'd3, 1'b0, 2'd2);
    chk_eq("R3 done bad speed", done, 1);
    chk_eq("R3 cmd_err bad speed", cmd_err, 1);
    wait_done("R3 done");
    chk_eq("R3 no scl change", n_sp + n_sr, 0);
    chk_eq("R3 no sda change", n_dp + n_dr, 0);
    issue(3'd6, 1'b0, 2'd1);
    chk_eq("R3 cmd_err bad op", cmd_err, 1);
    wait_done("R3 done");
    chk_eq("R3 lines untouched", n_sp + n_dp, 0);
  endtask

  task automatic t_start_plain;
    issue(3'd0, 1'b0, 2'd1);
    wait_done("R4 done");
    chk_eq("R4 single scl pull", n_sp, 1);
    chk_eq("R4 hold high phase", t_sp[0] - t_dp, FH);
    chk_eq("R4 low phase", t_done - t_sp[0], FL);
  endtask

  task automatic t_write_bits;
    issue(3'd3, 1'b0, 2'd1);
    wait_done("R8 done");
    chk_rng("R8 high phase", t_sp[0] - t_sr[0], FH + 1, FH + 4);
    chk_eq("R8 low phase", t_done - t_sp[0], FL);
    chk_eq("R8 sda held low for 0", sda_oe, 1);
    issue(3'd3, 1'b1, 2'd1);
    wait_done("R8 done");
    chk_eq("R8 sda released with scl", t_dr, t_sr[0]);
    issue(3'd3, 1'b1, 2'd0);
    wait_done("R2 done");
    chk_rng("R2 standard high", t_sp[0] - t_sr[0], SH + 1, SH + 4);
    chk_eq("R2 standard low", t_done - t_sp[0], SL);
  endtask

  task automatic t_read_bits;
    tgt_sda_low = 1'b1;
    issue(3'd4, 1'b0, 2'd1);
    wait_done("R9 done");
    chk_eq("R9 read 0", rd_bit, 0);
    chk_eq("R9 sda released", sda_oe, 0);
    tgt_sda_low = 1'b0;
    issue(3'd4, 1'b0, 2'd1);
    chk_eq("R9 rd_bit before done", rd_bit, 0);
    wait_done("R9 done");
    chk_eq("R9 read 1", rd_bit, 1);
    tgt_sda_low = 1'b1;
    issue(3'd3, 1'b0, 2'd1);
    wait_done("R9 done");
    chk_eq("R9 write leaves rd_bit", rd_bit, 1);
    tgt_sda_low = 1'b0;
  endtask

  task automatic t_rstart;
    issue(3'd1, 1'b0, 2'd1);
    wait_done("R6 done");
    chk_rng("R6 release wait", t_dp - t_sr[0], FH + FL + 2, FH + FL + 5);
    chk_eq("R6 start hold", t_sp[0] - t_dp, FH);
    chk_eq("R6 final low", t_done - t_sp[0], FL);
  endtask

  task automatic t_stop;
    issue(3'd2, 1'b0, 2'd1);
    wait_done("R7 done");
    chk_eq("R7 sda low before scl", t_sr[0] - t_acc, FL);
    chk_rng("R7 stop setup", t_dr - t_sr[0], 2 * FH + 1, 2 * FH + 4);
    chk_eq("R7 bus free", t_done - t_dr, FL);
    chk_eq("R7 lines free", scl_oe + sda_oe, 0);
  endtask

  task automatic t_start_recover;
    tgt_sda_low = 1'b1;
    issue(3'd0, 1'b0, 2'd1);
    wait (scl_oe);
    tgt_sda_low = 1'b0;
    wait_done("R5 done");
    chk_eq("R5 two scl pulls", n_sp, 2);
    chk_eq("R5 recovery low", t_sr[0] - t_sp[0], FL);
    chk_eq("R5 one sda pull", n_dp, 1);
    chk_eq("R5 start hold", t_sp[1] - t_dp, FH);
  endtask

  task automatic t_busy;
    issue(3'd3, 1'b1, 2'd1);
    @(negedge clk);
    chk_eq("R12 not ready while busy", cmd_ready, 0);
    cmd_op = 3'd2; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done("R12 done");
    repeat (2 * FL) @(negedge clk);
    chk_eq("R12 single done", n_done, 1);
    chk_eq("R12 scl still low", scl_oe, 1);
    chk_eq("R12 ready again", cmd_ready, 1);
  endtask

  task automatic t_stretch;
    int t_rel;
    tgt_scl_hold = 1'b1;
    issue(3'd3, 1'b1, 2'd1);
    repeat (200) @(negedge clk);
    t_rel = cyc;
    tgt_scl_hold = 1'b0;
    wait_done("R10 done");
    chk_rng("R10 high from real edge", t_sp[0] - t_rel, FH + 2, FH + 4);
    chk_eq("R10 no timeout", stretch_to, 0);
  endtask

  task automatic t_timeout;
    tgt_scl_hold = 1'b1;
    issue(3'd3, 1'b1, 2'd1);
    wait_done("R11 done");
    chk_rng("R11 high after timeout", t_sp[0] - t_sr[0], TO + FH - 1, TO + FH + 1);
    chk_eq("R11 flag set", stretch_to, 1);
    tgt_scl_hold = 1'b0;
    issue(3'd3, 1'b1, 2'd1);
    wait_done("R11 done");
    chk_eq("R11 flag sticky", stretch_to, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reject();
    t_start_plain();
    t_write_bits();
    t_read_bits();
    t_rstart();
    t_stop();
    t_start_recover();
    t_busy();
    t_stretch();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule